// File: doc/BRIEF.md
# Serial Configuration Memory Port Controller

This block owns a four-wire serial memory port: select, serial clock, data toward the memory and data back from it. It runs in one of two ways. A read engine fetches a block of 16-bit configuration words by itself, once after every hard reset and again whenever software asks. It adds up the bytes it received and publishes the words only when that sum is correct. Software can also drive the select, clock and data lines directly through control bits. This lets it run arbitrary memory commands by toggling the lines.

A presence input reports whether a memory is fitted. When none is fitted, the reset-time fetch stops after two serial clock periods and reports an invalid image. A software fetch ignores the presence input and always runs to the end. The control bits can only be changed while the surrounding controller reports stopped or suspended. While the hard reset input is low, the clock and data lines float and select is held low.

All control and status sits in one 8-bit register. Bit 0 is the fetch request. Bit 1 is the manual enable. Bit 2 is manual select, bit 3 is manual clock and bit 4 is manual data-out. Bit 5 is busy (read only), bit 6 is image valid (read only) and bit 7 is the live level of the data-in line (read only).

Top module: `seeprom_ctrl`

## Requirements
- R1: While `rst_n` is low, `ee_cs_o` is 0, and `ee_sk_oe_o` and `ee_do_oe_o` are both 0 (clock and data lines floating).
- R2: Hard reset clears register bits 0 to 4 (request, enable, select, clock, data-out) and the valid flag. All register bits are readable at the positions given above at any time.
- R3: A write to the register is ignored unless `stop_i` or `suspend_i` is 1. Bits 0 to 4 then read back unchanged and no fetch starts.
- R4: With enable (bit 1) at 1 and no fetch requested or running, the select, clock and data-out pins equal register bits 2, 3 and 4. A written value reaches the pins at the first clock edge after the write, and not before that edge.
- R5: With enable at 0 and no fetch requested or running, the select, clock and data-out pins are driven low, with both output enables at 1, whatever bits 2 to 4 hold.
- R6: During a fetch the select pin is high throughout. The first nine data-out bits, launched while the serial clock is low, are the read opcode 3'b110 followed by the 6-bit start address 0, most significant bit first.
- R7: After the command, the engine takes in NWORDS×16 bits, sampling `ee_di_i` at each serial clock rising edge, most significant bit first. The first word received becomes word 0, at bits [15:0] of `cfg_words_o`.
- R8: After hard reset with `present_i`=1, a full fetch of 9+NWORDS×16 serial clock rising edges runs. With `present_i`=0, exactly two rising edges are produced, the fetch ends, and valid reads 0.
- R9: A software fetch (bit 0 written to 1) runs the full sequence whatever the level of `present_i`.
- R10: When the 8-bit sum of all received bytes, modulo 256, equals 8'hFF, valid becomes 1 and the words are copied to `cfg_words_o`. Otherwise valid becomes 0 and `cfg_words_o` keeps its old contents. Valid changes only when a fetch ends.
- R11: The request bit clears itself when the fetch ends, and busy stays 1 for the whole fetch. While a fetch is requested or running, the pins follow the engine and the manual bits have no effect.
- R12: A one-cycle `soft_rst_i` pulse ends any fetch (busy and request go to 0) and leaves bits 1 to 4 unchanged.
- R13: During a fetch the serial clock is high for CLK_DIV/2 system clocks and low for CLK_DIV/2 system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hard reset, active low; also floats the port pins |
| soft_rst_i | input | 1 | Soft reset pulse; ends a fetch, keeps control bits |
| stop_i | input | 1 | Surrounding controller is stopped; opens register writes |
| suspend_i | input | 1 | Surrounding controller is suspended; opens register writes |
| present_i | input | 1 | Memory fitted indication, used by the reset-time fetch |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| busy_o | output | 1 | Fetch in progress |
| valid_o | output | 1 | Last completed fetch passed its checksum |
| cfg_words_o | output | NWORDS×16 | Loaded words, word i at [16i+15:16i] |
| ee_cs_o | output | 1 | Memory select |
| ee_sk_o | output | 1 | Serial clock level |
| ee_sk_oe_o | output | 1 | Serial clock output enable |
| ee_do_o | output | 1 | Data toward the memory |
| ee_do_oe_o | output | 1 | Data-out output enable |
| ee_di_i | input | 1 | Data from the memory |

## Verification
The bench aims at the gap between a requested fetch and a running one. If the design let the manual bits reach the pins during that gap, the select line would drop in the middle of a fetch. It also targets the presence-driven abort. A design that counted falling edges wrongly would produce one or three clock pulses instead of two, or would leave busy stuck high. A failing checksum must leave the published words untouched. Because the words are copied only on a pass, a design that copied them unconditionally would show corrupted words next to a cleared valid flag. Writes made while the controller is neither stopped nor suspended must have no effect on readback or pins. The exact edge at which a manual write reaches the pins is also checked.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_SHIFT = 2'd1,
      RD_DONE  = 2'd2
   } rd_state_e;

   typedef struct packed {
      logic cs;
      logic sk;
      logic dout;
   } port_pins_t;

   localparam int unsigned REG_W   = 8;
   localparam int unsigned B_REQ   = 0;
   localparam int unsigned B_EN    = 1;
   localparam int unsigned B_CS    = 2;
   localparam int unsigned B_SK    = 3;
   localparam int unsigned B_DO    = 4;
   localparam int unsigned B_BUSY  = 5;
   localparam int unsigned B_VALID = 6;
   localparam int unsigned B_DI    = 7;
endpackage

// File: rtl/seeprom_tick.sv
module seeprom_tick #(
   parameter int unsigned CLK_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   localparam int unsigned HALF  = CLK_DIV / 2;
   localparam int unsigned CNT_W = (HALF > 1) ? $clog2(HALF) : 1;

   generate
      if (HALF == 1) begin : g_every_cycle
         assign tick = rst_n & ~clr;
      end else begin : g_counted
         logic [CNT_W-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (clr) begin
               cnt <= '0;
            end else if (cnt == CNT_W'(HALF - 1)) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign tick = (cnt == CNT_W'(HALF - 1)) & ~clr;
      end
   endgenerate
endmodule

// File: rtl/seeprom_reader.sv
module seeprom_reader
   import seeprom_pkg::*;
#(
   parameter int unsigned NWORDS     = 4,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned START_ADDR = 0,
   parameter logic [2:0]  OPCODE     = 3'b110,
   parameter int unsigned CLK_DIV    = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     soft_rst,
   input  logic                     start,
   input  logic                     short_mode,
   input  logic                     ee_di,
   output logic                     busy,
   output logic                     done,
   output logic                     sum_ok,
   output port_pins_t               pins,
   output logic [NWORDS*16-1:0]     data
);
   localparam int unsigned CMD_W     = 3 + ADDR_W;
   localparam int unsigned DATA_BITS = NWORDS * 16;
   localparam int unsigned TOTAL     = CMD_W + DATA_BITS;
   localparam int unsigned CNT_W     = $clog2(TOTAL + 1);
   localparam int unsigned NBYTES    = NWORDS * 2;
   localparam logic [CMD_W-1:0] CMD  = {OPCODE, ADDR_W'(START_ADDR)};

   rd_state_e              st;
   logic [CNT_W-1:0]       bitcnt;
   logic                   cs_q, sk_q, do_q, short_q;
   logic [DATA_BITS-1:0]   shreg;
   logic                   tick;
   logic [7:0]             bsum;

   function automatic logic cmd_bit(input logic [CNT_W-1:0] idx);
      logic [CMD_W-1:0] t;
      t = CMD << idx;
      return t[CMD_W-1];
   endfunction

   seeprom_tick #(.CLK_DIV(CLK_DIV)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st != RD_SHIFT),
      .tick  (tick)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= RD_IDLE;
         bitcnt  <= '0;
         cs_q    <= 1'b0;
         sk_q    <= 1'b0;
         do_q    <= 1'b0;
         short_q <= 1'b0;
         shreg   <= '0;
      end else if (soft_rst) begin
         st   <= RD_IDLE;
         cs_q <= 1'b0;
         sk_q <= 1'b0;
         do_q <= 1'b0;
      end else begin
         case (st)
            RD_IDLE: begin
               if (start) begin
                  st      <= RD_SHIFT;
                  cs_q    <= 1'b1;
                  sk_q    <= 1'b0;
                  do_q    <= CMD[CMD_W-1];
                  bitcnt  <= '0;
                  short_q <= short_mode;
               end
            end
            RD_SHIFT: begin
               if (tick) begin
                  if (!sk_q) begin
                     sk_q <= 1'b1;
                     if (bitcnt >= CNT_W'(CMD_W)) begin
                        shreg <= {shreg[DATA_BITS-2:0], ee_di};
                     end
                  end else begin
                     sk_q <= 1'b0;
                     if ((bitcnt == CNT_W'(TOTAL - 1)) ||
                         (short_q && (bitcnt == CNT_W'(1)))) begin
                        st   <= RD_DONE;
                        do_q <= 1'b0;
                     end else begin
                        bitcnt <= bitcnt + 1'b1;
                        do_q   <= cmd_bit(bitcnt + 1'b1);
                     end
                  end
               end
            end
            RD_DONE: begin
               st   <= RD_IDLE;
               cs_q <= 1'b0;
            end
            default: st <= RD_IDLE;
         endcase
      end
   end

   always_comb begin
      bsum = '0;
      for (int b = 0; b < NBYTES; b++) begin
         bsum = bsum + shreg[b*8 +: 8];
      end
   end

   assign busy   = (st != RD_IDLE);
   assign done   = (st == RD_DONE) & ~soft_rst;
   assign sum_ok = (bsum == 8'hFF) & ~short_q;
   assign data   = shreg;
   assign pins   = '{cs: cs_q, sk: sk_q, dout: do_q};
endmodule

// File: rtl/seeprom_pinmux.sv
module seeprom_pinmux
   import seeprom_pkg::*;
(
   input  logic       rst_n,
   input  logic       eng_sel,
   input  logic       man_en,
   input  port_pins_t eng,
   input  port_pins_t man,
   output logic       cs_o,
   output logic       sk_o,
   output logic       sk_oe_o,
   output logic       do_o,
   output logic       do_oe_o
);
   port_pins_t sel;

   always_comb begin
      if (eng_sel) begin
         sel = eng;
      end else if (man_en) begin
         sel = man;
      end else begin
         sel = '0;
      end
      if (!rst_n) begin
         cs_o    = 1'b0;
         sk_o    = 1'b0;
         do_o    = 1'b0;
         sk_oe_o = 1'b0;
         do_oe_o = 1'b0;
      end else begin
         cs_o    = sel.cs;
         sk_o    = sel.sk;
         do_o    = sel.dout;
         sk_oe_o = 1'b1;
         do_oe_o = 1'b1;
      end
   end
endmodule

// File: rtl/seeprom_ctrl.sv
module seeprom_ctrl
   import seeprom_pkg::*;
#(
   parameter int unsigned NWORDS     = 4,
   parameter int unsigned ADDR_W     = 6,
   parameter int unsigned START_ADDR = 0,
   parameter logic [2:0]  OPCODE     = 3'b110,
   parameter int unsigned CLK_DIV    = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 soft_rst_i,
   input  logic                 stop_i,
   input  logic                 suspend_i,
   input  logic                 present_i,
   input  logic                 reg_we_i,
   input  logic [7:0]           reg_wdata_i,
   output logic [7:0]           reg_rdata_o,
   output logic                 busy_o,
   output logic                 valid_o,
   output logic [NWORDS*16-1:0] cfg_words_o,
   output logic                 ee_cs_o,
   output logic                 ee_sk_o,
   output logic                 ee_sk_oe_o,
   output logic                 ee_do_o,
   output logic                 ee_do_oe_o,
   input  logic                 ee_di_i
);
   localparam int unsigned DATA_BITS = NWORDS * 16;

   if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
      $error("seeprom_ctrl: CLK_DIV must be even and at least 2");
   end
   if (NWORDS < 1) begin : g_bad_words
      $error("seeprom_ctrl: NWORDS must be at least 1");
   end
   if (ADDR_W < 1 || START_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
      $error("seeprom_ctrl: START_ADDR must fit in ADDR_W bits");
   end

   logic                 en_q, cs_q, sk_q, do_q, req_q, valid_q, auto_pend;
   logic [DATA_BITS-1:0] bank_q;
   logic                 eng_busy, eng_done, eng_ok, start, wr_ok;
   logic [DATA_BITS-1:0] eng_data;
   logic [DATA_BITS-1:0] eng_words;
   port_pins_t           eng_pins;

   assign wr_ok = stop_i | suspend_i;
   assign start = ~eng_busy & (auto_pend | req_q) & ~soft_rst_i;

   seeprom_reader #(
      .NWORDS     (NWORDS),
      .ADDR_W     (ADDR_W),
      .START_ADDR (START_ADDR),
      .OPCODE     (OPCODE),
      .CLK_DIV    (CLK_DIV)
   ) u_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst_i),
      .start      (start),
      .short_mode (auto_pend & ~present_i),
      .ee_di      (ee_di_i),
      .busy       (eng_busy),
      .done       (eng_done),
      .sum_ok     (eng_ok),
      .pins       (eng_pins),
      .data       (eng_data)
   );

   // first word received sits at the top of the shift register
   for (genvar w = 0; w < NWORDS; w++) begin : g_word_map
      assign eng_words[w*16 +: 16] = eng_data[(NWORDS-1-w)*16 +: 16];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         cs_q      <= 1'b0;
         sk_q      <= 1'b0;
         do_q      <= 1'b0;
         req_q     <= 1'b0;
         valid_q   <= 1'b0;
         auto_pend <= 1'b1;
         bank_q    <= '0;
      end else begin
         if (start) begin
            auto_pend <= 1'b0;
         end
         if (reg_we_i && wr_ok) begin
            req_q <= reg_wdata_i[B_REQ];
            en_q  <= reg_wdata_i[B_EN];
            cs_q  <= reg_wdata_i[B_CS];
            sk_q  <= reg_wdata_i[B_SK];
            do_q  <= reg_wdata_i[B_DO];
         end
         if (eng_done || soft_rst_i) begin
            req_q <= 1'b0;
         end
         if (eng_done) begin
            valid_q <= eng_ok;
            if (eng_ok) begin
               bank_q <= eng_words;
            end
         end
      end
   end

   seeprom_pinmux u_pinmux (
      .rst_n   (rst_n),
      .eng_sel (eng_busy | req_q | auto_pend),
      .man_en  (en_q),
      .eng     (eng_pins),
      .man     ('{cs: cs_q, sk: sk_q, dout: do_q}),
      .cs_o    (ee_cs_o),
      .sk_o    (ee_sk_o),
      .sk_oe_o (ee_sk_oe_o),
      .do_o    (ee_do_o),
      .do_oe_o (ee_do_oe_o)
   );

   assign reg_rdata_o = {ee_di_i, valid_q, eng_busy, do_q, sk_q, cs_q, en_q, req_q};
   assign busy_o      = eng_busy;
   assign valid_o     = valid_q;
   assign cfg_words_o = bank_q;
endmodule

// File: rtl/seeprom_ctrl_chk.sv
module seeprom_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_i,
   input logic       suspend_i,
   input logic       reg_we_i,
   input logic [7:0] reg_rdata_o,
   input logic       busy_o,
   input logic       valid_o,
   input logic       ee_cs_o,
   input logic       ee_sk_o,
   input logic       ee_sk_oe_o,
   input logic       ee_do_o,
   input logic       ee_do_oe_o
);
   p_reset_pins_r1: assert property (@(posedge clk)
      !rst_n |-> (!ee_cs_o && !ee_sk_oe_o && !ee_do_oe_o));

   p_write_locked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && !stop_i && !suspend_i) |=> $stable(reg_rdata_o[4:1]));

   p_disabled_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !reg_rdata_o[0] && !reg_rdata_o[1])
         |-> (!ee_cs_o && !ee_sk_o && !ee_do_o && ee_sk_oe_o && ee_do_oe_o));

   p_cs_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (ee_cs_o && ee_sk_oe_o));

   p_valid_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(busy_o) |-> $stable(valid_o));

   p_req_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> !reg_rdata_o[0]);
endmodule

bind seeprom_ctrl seeprom_ctrl_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .stop_i      (stop_i),
   .suspend_i   (suspend_i),
   .reg_we_i    (reg_we_i),
   .reg_rdata_o (reg_rdata_o),
   .busy_o      (busy_o),
   .valid_o     (valid_o),
   .ee_cs_o     (ee_cs_o),
   .ee_sk_o     (ee_sk_o),
   .ee_sk_oe_o  (ee_sk_oe_o),
   .ee_do_o     (ee_do_o),
   .ee_do_oe_o  (ee_do_oe_o)
);

// File: tb/seeprom_ctrl_bench.sv
`timescale 1ns/1ps
module seeprom_ctrl_bench;
   localparam int NW    = 4;
   localparam int DIV   = 4;
   localparam int FULL  = 9 + NW*16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0, stop = 1'b0, susp = 1'b0, present = 1'b1;
   logic we = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic busy, valid;
   logic [NW*16-1:0] words;
   logic cs, sk, sk_oe, dout, do_oe;
   logic di = 1'b0;

   int n_chk = 0, n_fail = 0;
   int rises = 0, rise_base = 0;
   logic [8:0] cmd_seen = '0;
   logic [15:0] img [NW];
   logic [15:0] good [NW];

   always #4 clk = ~clk;

   seeprom_ctrl #(.NWORDS(NW), .CLK_DIV(DIV)) u_seeprom_ctrl (
      .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst), .stop_i(stop),
      .suspend_i(susp), .present_i(present), .reg_we_i(we),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata), .busy_o(busy),
      .valid_o(valid), .cfg_words_o(words), .ee_cs_o(cs), .ee_sk_o(sk),
      .ee_sk_oe_o(sk_oe), .ee_do_o(dout), .ee_do_oe_o(do_oe), .ee_di_i(di)
   );

   // memory model: capture command bits, present data before each rising edge
   always @(posedge sk) begin
      if (cs) begin
         if (rises - rise_base == 0) cmd_seen = {8'b0, dout};
         else if (rises - rise_base < 9) cmd_seen = {cmd_seen[7:0], dout};
         rises = rises + 1;
      end
   end
   always @(negedge sk) begin
      if (cs && (rises - rise_base) >= 9 && (rises - rise_base) < FULL)
         di = img[(rises - rise_base - 9) / 16][15 - ((rises - rise_base - 9) % 16)];
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic make_image();
      logic [7:0] s;
      img[0] = 16'h1234; img[1] = 16'hA5C3; img[2] = 16'h0F0F;
      s = 8'h12 + 8'h34 + 8'hA5 + 8'hC3 + 8'h0F + 8'h0F + 8'h5A;
      img[3] = {8'h5A, 8'hFF - s};
      for (int i = 0; i < NW; i++) good[i] = img[i];
   endtask

   task automatic wait_idle();
      int n = 0;
      repeat (3) @(negedge clk);
      while (busy && n < 5000) begin @(negedge clk); n++; end
      repeat (2) @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      @(negedge clk); we = 1'b1; wdata = v;
      @(negedge clk); we = 1'b0;
   endtask

   task automatic check_words(input string req);
      for (int i = 0; i < NW; i++)
         chk(words[i*16 +: 16] == good[i], req, "loaded word", words[i*16 +: 16], good[i]);
   endtask

   task automatic t_reset_and_auto();
      make_image();
      present = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(!cs && !sk_oe && !do_oe, "R1", "pins in reset", {cs, sk_oe, do_oe}, 0);
      chk(rdata[4:0] == 5'd0 && !valid, "R2", "bits after hard reset", rdata, 0);
      rise_base = rises;
      rst_n = 1'b1;
      wait_idle();
      chk(rises - rise_base == FULL, "R8", "auto fetch edges present", rises - rise_base, FULL);
      chk(cmd_seen == 9'b110_000000, "R6", "command bits", cmd_seen, 9'b110_000000);
      chk(valid == 1'b1, "R10", "valid after good sum", valid, 1);
      check_words("R7");
      chk(rdata[0] == 1'b0 && rdata[5] == 1'b0, "R11", "request/busy idle", rdata[5:0], 0);
   endtask

   task automatic t_write_lock();
      stop = 1'b0; susp = 1'b0;
      wr(8'h1F);
      repeat (3) @(negedge clk);
      chk(rdata[4:0] == 5'd0, "R3", "locked write ignored", rdata[4:0], 0);
      chk(!busy, "R3", "no fetch from locked write", busy, 0);
      chk(!cs && !sk && !dout && sk_oe && do_oe, "R5", "pins low while disabled",
          {cs, sk, dout, sk_oe, do_oe}, 5'b00011);
   endtask

   task automatic t_manual();
      susp = 1'b1;
      @(negedge clk); we = 1'b1; wdata = 8'h1E;
      chk(!cs, "R4", "pin before edge", cs, 0);
      @(negedge clk); we = 1'b0;
      chk(cs && sk && dout, "R4", "pins after edge", {cs, sk, dout}, 3'b111);
      chk(rdata[4:1] == 4'hF, "R2", "readback of manual bits", rdata[4:1], 4'hF);
      wr(8'h0A);
      chk(!cs && sk && !dout, "R4", "pins follow new bits", {cs, sk, dout}, 3'b010);
      susp = 1'b0;
   endtask

   task automatic t_disabled();
      stop = 1'b1;
      wr(8'h1C);
      chk(!cs && !sk && !dout, "R5", "enable 0 forces low", {cs, sk, dout}, 0);
      stop = 1'b0;
   endtask

   task automatic t_soft_reset();
      stop = 1'b1;
      wr(8'h1E);
      @(negedge clk); soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      chk(rdata[4:1] == 4'hF, "R12", "bits kept over soft reset", rdata[4:1], 4'hF);
      rise_base = rises;
      wr(8'h1F);
      repeat (20) @(negedge clk);
      chk(busy, "R11", "busy mid fetch", busy, 1);
      soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      chk(!busy && !rdata[0], "R12", "fetch ended by soft reset", {busy, rdata[0]}, 0);
      chk(rdata[4:1] == 4'hF, "R12", "bits kept after abort", rdata[4:1], 4'hF);
      wr(8'h00);
      stop = 1'b0;
   endtask

   task automatic t_sw_read();
      int hi = 0, lo = 0;
      present = 1'b0;
      stop = 1'b1;
      rise_base = rises;
      wr(8'h01);
      while (!sk) @(negedge clk);
      while (sk) begin hi++; @(negedge clk); end
      while (!sk) begin lo++; @(negedge clk); end
      chk(hi == DIV/2 && lo == DIV/2, "R13", "serial clock halves", {hi, lo}, {DIV/2, DIV/2});
      chk(busy && rdata[5], "R11", "busy during fetch", busy, 1);
      @(negedge clk); we = 1'b1; wdata = 8'h03;
      @(negedge clk); we = 1'b0;
      chk(cs, "R11", "manual select ignored during fetch", cs, 1);
      wait_idle();
      chk(rises - rise_base == FULL, "R9", "software fetch ignores presence", rises - rise_base, FULL);
      chk(valid && rdata[6], "R9", "valid after software fetch", valid, 1);
      chk(!rdata[0], "R11", "request self clears", rdata[0], 0);
      wr(8'h00);
      stop = 1'b0;
   endtask

   task automatic t_bad_sum();
      img[3] = img[3] ^ 16'h0001;
      stop = 1'b1;
      wr(8'h01);
      wait_idle();
      chk(!valid, "R10", "valid cleared on bad sum", valid, 0);
      check_words("R10");
      img[3] = good[3];
      stop = 1'b0;
   endtask

   task automatic t_abort();
      present = 1'b0;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rise_base = rises;
      rst_n = 1'b1;
      wait_idle();
      chk(rises - rise_base == 2, "R8", "absent memory aborts after two edges", rises - rise_base, 2);
      chk(!valid && !busy, "R8", "valid cleared on abort", {valid, busy}, 0);
   endtask

   initial begin
      t_reset_and_auto();
      t_write_lock();
      t_manual();
      t_disabled();
      t_soft_reset();
      t_sw_read();
      t_bad_sum();
      t_abort();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule